// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block computes B^E mod M for an odd modulus M. It drives one bit-serial radix-2 Montgomery multiplier. The caller supplies four values: the exponent, the modulus, the base already mapped into the Montgomery domain (B·2^W mod M), and the Montgomery image of one (2^W mod M). The sequencer seeds its accumulator with the image of one. It then walks the exponent from the most significant bit to the least. Each bit costs one Montgomery squaring of the accumulator, and a bit that is set adds a Montgomery product of the mapped base with the accumulator. A final Montgomery product with the constant 1 maps the accumulator back to an ordinary residue.

The four operands are captured when `start` is accepted, and `start` is only accepted while the sequencer is idle. The answer appears on `result` in the same cycle as a single-cycle `done` pulse. It stays on `result` until the next operation completes. The multiplier keeps its running sum two bits wider than the operands, so a modulus that fills the whole word, with its top bit set, is handled the same way as a small one.

Top module: `modexp_ctrl`

## Requirements
- R1: With M odd and greater than 1, B less than M, `base_mont` = B·2^W mod M and `one_mont` = 2^W mod M, the value on `result` while `done` is high equals B^E mod M. This includes B = 0 and B = M-1.
- R2: R1 holds for full-width odd moduli whose bit W-1 is set, up to and including M = 2^W-1. The multiplier's internal partial sum stays below 2M.
- R3: An exponent of zero produces 1 mod M through the normal sequence.
- R4: Exponent bits are consumed from bit W-1 down to bit 0. Every bit is squared first, and a multiply follows only for a bit equal to 1. Exponents with only bit W-1 set, only bit 0 set, or all bits set each give the value of R1.
- R5: `done` is high for exactly one cycle per accepted operation. `result` keeps its value after that pulse until the next operation finishes.
- R6: A `start` that arrives while an operation is running, or in the cycle `done` is high, is ignored. Operand inputs that change during a run have no effect on the answer, and no extra `done` pulse follows.
- R7: After reset, `done` is low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a new exponentiation; honoured only when idle |
| exponent | input | W | Exponent E |
| modulus | input | W | Odd modulus M |
| base_mont | input | W | Base in Montgomery form, B·2^W mod M |
| one_mont | input | W | Montgomery form of one, 2^W mod M |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | B^E mod M, held until the next completion |

## Verification
Two of this block's functions can meet in one cycle: the completion pulse of one operation, and a new `start` request. The bench provokes this by raising `start` with different operands on exactly the cycle it sees `done` high. It judges the outcome through the scoreboard. Any further `done` pulse without a queued expectation is a failure, and `result` must still hold the earlier answer. A second case places a `start` with altered operands in the middle of a running exponentiation, and the expected value remains the one for the original operands.

// File: rtl/modexp_pkg.sv
// Shared types for the Montgomery exponentiation sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package modexp_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_SQUARE   = 3'd1,
        SEQ_MULTIPLY = 3'd2,
        SEQ_CONVERT  = 3'd3,
        SEQ_DONE     = 3'd4
    } seq_state_t;

    // Operand pairing requested from the datapath.
    typedef enum logic [1:0] {
        PAIR_SQUARE  = 2'd0,   // acc * acc
        PAIR_BASE    = 2'd1,   // base * acc
        PAIR_UNIT    = 2'd2    // acc * 1
    } pair_sel_t;

    // Multiplier phases.
    typedef enum logic [1:0] {
        MM_IDLE = 2'd0,
        MM_RUN  = 2'd1,
        MM_FIN  = 2'd2
    } mm_state_t;

endpackage

// File: rtl/modexp_montmul.sv
// Bit-serial radix-2 Montgomery multiplier: prod = X*Y*2^-W mod M.
// Takes one cycle per bit of X, plus one cycle for the final subtraction.
// Assumes M is odd, Y < M and X < 2^W. The running sum is kept W+2 bits
// wide, so it never wraps even when M fills the whole word.
// A start pulse is honoured only while idle. done is a registered
// one-cycle pulse, and prod is valid in that same cycle.
module modexp_montmul
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] op_m,
    output logic         done,
    output logic [W-1:0] prod
);

    localparam int SW = W + 2;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    mm_state_t       phase_q;
    logic [CW-1:0]   cnt_q;
    logic [W-1:0]    x_q;
    logic [SW-1:0]   y_q;
    logic [SW-1:0]   m_q;
    logic [SW-1:0]   s_q;
    logic [SW-1:0]   sum_y;
    logic [SW-1:0]   sum_m;
    logic [SW-1:0]   s_next;
    logic [SW-1:0]   s_less_m;
    logic [W-1:0]    fin_val;
    logic            done_q;
    logic [W-1:0]    prod_q;

    // One iteration: add X bit times Y, make the sum even with M, then halve.
    always_comb begin
        sum_y  = s_q + (x_q[0] ? y_q : '0);
        sum_m  = sum_y[0] ? (sum_y + m_q) : sum_y;
        s_next = sum_m >> 1;
    end

    // Final conditional subtraction brings the sum from below 2M to below M.
    always_comb begin
        s_less_m = s_q - m_q;
        fin_val  = (s_q >= m_q) ? s_less_m[W-1:0] : s_q[W-1:0];
    end

    // Phase, counter, operand and sum registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= MM_IDLE;
            cnt_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            m_q     <= '0;
            s_q     <= '0;
            done_q  <= 1'b0;
            prod_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                MM_IDLE: begin
                    if (start) begin
                        x_q     <= op_x;
                        y_q     <= {2'b00, op_y};
                        m_q     <= {2'b00, op_m};
                        s_q     <= '0;
                        cnt_q   <= '0;
                        phase_q <= MM_RUN;
                    end
                end
                MM_RUN: begin
                    s_q <= s_next;
                    x_q <= x_q >> 1;
                    if (cnt_q == LAST) begin
                        phase_q <= MM_FIN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                MM_FIN: begin
                    prod_q  <= fin_val;
                    done_q  <= 1'b1;
                    phase_q <= MM_IDLE;
                end
                default: phase_q <= MM_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign prod = prod_q;

    // R2: the partial sum never reaches 2M, so W+2 bits always suffice.
    a_r2_partial_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == MM_RUN) |-> (s_q < (m_q << 1)));

    // R1: every product handed back is already reduced below the modulus.
    a_r1_prod_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ({2'b00, prod_q} < m_q));

    // R6: the sequencer never launches a product while one is in flight.
    a_r6_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase_q == MM_IDLE));

endmodule

// File: rtl/modexp_operands.sv
// Operand store for the exponentiation: captures exponent, modulus,
// mapped base and mapped one at load, and keeps the Montgomery
// accumulator and the held result. It presents the multiplier operand
// pair selected by the sequencer and the exponent bit the sequencer
// is pointing at.
// Assumes load, acc_we and res_we come from the sequencer and are never
// raised together.
module modexp_operands
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 acc_we,
    input  logic                 res_we,
    input  pair_sel_t            sel,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic [W-1:0]         exponent,
    input  logic [W-1:0]         modulus,
    input  logic [W-1:0]         base_mont,
    input  logic [W-1:0]         one_mont,
    input  logic [W-1:0]         mul_prod,
    output logic [W-1:0]         mul_x,
    output logic [W-1:0]         mul_y,
    output logic [W-1:0]         mul_m,
    output logic                 cur_bit,
    output logic [W-1:0]         result
);

    localparam logic [W-1:0] UNIT = W'(1);

    logic [W-1:0] e_q;
    logic [W-1:0] m_q;
    logic [W-1:0] b_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] res_q;

    // Capture operands on load; the accumulator starts at the image of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q   <= '0;
            m_q   <= '0;
            b_q   <= '0;
            acc_q <= '0;
        end else if (load) begin
            e_q   <= exponent;
            m_q   <= modulus;
            b_q   <= base_mont;
            acc_q <= one_mont;
        end else if (acc_we) begin
            acc_q <= mul_prod;
        end
    end

    // Result register, written only by the final conversion product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (res_we) begin
            res_q <= mul_prod;
        end
    end

    // Operand pair for the multiplier; X is the operand it scans bit by bit.
    always_comb begin
        case (sel)
            PAIR_SQUARE: begin mul_x = acc_q; mul_y = acc_q; end
            PAIR_BASE:   begin mul_x = b_q;   mul_y = acc_q; end
            PAIR_UNIT:   begin mul_x = acc_q; mul_y = UNIT;  end
            default:     begin mul_x = acc_q; mul_y = acc_q; end
        endcase
    end

    assign mul_m   = m_q;
    assign cur_bit = e_q[bit_idx];
    assign result  = res_q;

endmodule

// File: rtl/modexp_fsm.sv
// Sequencer for left-to-right square-and-multiply in the Montgomery domain.
// Per exponent bit, from W-1 down to 0, it issues a square and, for a set
// bit, a product with the mapped base. It ends with a product by one.
// It issues one multiplier start per state and waits for the multiplier's
// done pulse before it moves on.
// Assumes W is a power of two, so the bit index spans the exponent.
module modexp_fsm
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cur_bit,
    input  logic                 mul_done,
    output logic                 load,
    output logic                 acc_we,
    output logic                 res_we,
    output logic                 mul_start,
    output pair_sel_t            sel,
    output logic [$clog2(W)-1:0] bit_idx,
    output logic                 done
);

    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] TOP = BW'(W - 1);

    seq_state_t    state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;
    logic          issued_q, issued_d;

    // Next-state, strobe and operand-select logic.
    always_comb begin
        state_d   = state_q;
        bit_d     = bit_q;
        issued_d  = issued_q;
        load      = 1'b0;
        acc_we    = 1'b0;
        res_we    = 1'b0;
        mul_start = 1'b0;
        sel       = PAIR_SQUARE;
        case (state_q)
            SEQ_IDLE: begin
                if (start) begin
                    load     = 1'b1;
                    bit_d    = TOP;
                    issued_d = 1'b0;
                    state_d  = SEQ_SQUARE;
                end
            end
            SEQ_SQUARE, SEQ_MULTIPLY: begin
                sel = (state_q == SEQ_SQUARE) ? PAIR_SQUARE : PAIR_BASE;
                if (!issued_q) begin
                    mul_start = 1'b1;
                    issued_d  = 1'b1;
                end else if (mul_done) begin
                    acc_we   = 1'b1;
                    issued_d = 1'b0;
                    if (state_q == SEQ_SQUARE && cur_bit) begin
                        state_d = SEQ_MULTIPLY;
                    end else if (bit_q == '0) begin
                        state_d = SEQ_CONVERT;
                    end else begin
                        bit_d   = bit_q - 1'b1;
                        state_d = SEQ_SQUARE;
                    end
                end
            end
            SEQ_CONVERT: begin
                sel = PAIR_UNIT;
                if (!issued_q) begin
                    mul_start = 1'b1;
                    issued_d  = 1'b1;
                end else if (mul_done) begin
                    res_we   = 1'b1;
                    issued_d = 1'b0;
                    state_d  = SEQ_DONE;
                end
            end
            SEQ_DONE: state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // State, bit index and issue-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            bit_q    <= '0;
            issued_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            bit_q    <= bit_d;
            issued_q <= issued_d;
        end
    end

    assign bit_idx = bit_q;
    assign done    = (state_q == SEQ_DONE);

    // R4: a multiply step is only ever entered straight from a square.
    a_r4_mul_after_square: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_MULTIPLY && $past(state_q) != SEQ_MULTIPLY)
        |-> ($past(state_q) == SEQ_SQUARE));

    // R4: conversion starts only once bit 0 has been handled.
    a_r4_convert_after_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_CONVERT && $past(state_q) != SEQ_CONVERT)
        |-> ($past(bit_q) == '0));

    // R5: completion is a single-cycle pulse.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: the result register changes only on completion of a conversion.
    a_r6_result_on_convert: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |=> (state_q == SEQ_DONE));

endmodule

// File: rtl/modexp_ctrl.sv
// Top level of the Montgomery exponentiation sequencer: connects the
// sequencer, the operand store and one bit-serial Montgomery multiplier.
// Assumes an odd modulus above 1, a mapped base below the modulus, and
// W a power of two.
module modexp_ctrl
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] exponent,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] base_mont,
    input  logic [W-1:0] one_mont,
    output logic         done,
    output logic [W-1:0] result
);

    localparam int BW = $clog2(W);

    logic          load;
    logic          acc_we;
    logic          res_we;
    logic          mul_start;
    logic          mul_done;
    pair_sel_t     sel;
    logic [BW-1:0] bit_idx;
    logic          cur_bit;
    logic [W-1:0]  mul_x;
    logic [W-1:0]  mul_y;
    logic [W-1:0]  mul_m;
    logic [W-1:0]  mul_prod;

    modexp_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cur_bit   (cur_bit),
        .mul_done  (mul_done),
        .load      (load),
        .acc_we    (acc_we),
        .res_we    (res_we),
        .mul_start (mul_start),
        .sel       (sel),
        .bit_idx   (bit_idx),
        .done      (done)
    );

    modexp_operands #(.W(W)) u_operands (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .acc_we    (acc_we),
        .res_we    (res_we),
        .sel       (sel),
        .bit_idx   (bit_idx),
        .exponent  (exponent),
        .modulus   (modulus),
        .base_mont (base_mont),
        .one_mont  (one_mont),
        .mul_prod  (mul_prod),
        .mul_x     (mul_x),
        .mul_y     (mul_y),
        .mul_m     (mul_m),
        .cur_bit   (cur_bit),
        .result    (result)
    );

    modexp_montmul #(.W(W)) u_montmul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .op_x  (mul_x),
        .op_y  (mul_y),
        .op_m  (mul_m),
        .done  (mul_done),
        .prod  (mul_prod)
    );

endmodule

// File: tb/modexp_ctrl_bench.sv
// Scoreboard bench: the driver pushes expected results into a queue and
// the monitor pops and compares them on every done pulse.
module modexp_ctrl_bench;

    localparam int W = 32;

    typedef struct {
        logic [W-1:0] value;
        string        tag;
    } exp_item_t;

    logic         clk;
    logic         rst_n;
    logic         start;
    logic [W-1:0] exponent;
    logic [W-1:0] modulus;
    logic [W-1:0] base_mont;
    logic [W-1:0] one_mont;
    logic         done;
    logic [W-1:0] result;

    int checks;
    int fails;
    exp_item_t sb_q[$];
    logic      done_prev;

    modexp_ctrl #(.W(W)) u_modexp_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .exponent  (exponent),
        .modulus   (modulus),
        .base_mont (base_mont),
        .one_mont  (one_mont),
        .done      (done),
        .result    (result)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Plain modular exponentiation on double-width arithmetic.
    function automatic logic [W-1:0] ref_pow(logic [W-1:0] b, logic [W-1:0] e,
                                             logic [W-1:0] m);
        logic [2*W-1:0] r;
        logic [2*W-1:0] bb;
        bb = {{W{1'b0}}, b} % {{W{1'b0}}, m};
        r  = {{W{1'b0}}, W'(1)} % {{W{1'b0}}, m};
        for (int i = W - 1; i >= 0; i--) begin
            r = (r * r) % {{W{1'b0}}, m};
            if (e[i]) r = (r * bb) % {{W{1'b0}}, m};
        end
        return r[W-1:0];
    endfunction

    // Montgomery image v*2^W mod m.
    function automatic logic [W-1:0] to_mont(logic [W-1:0] v, logic [W-1:0] m);
        logic [2*W-1:0] t;
        t = {v, {W{1'b0}}} % {{W{1'b0}}, m};
        return t[W-1:0];
    endfunction

    task automatic check(bit ok, string tag, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: compare each done pulse against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done && done_prev)
                check(1'b0, "R5 done longer than one cycle", {W{1'b1}}, '0);
            else if (done_prev)
                check(1'b1, "R5", '0, '0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", result, '0);
                end else begin
                    exp_item_t it;
                    it = sb_q.pop_front();
                    check(result == it.value, it.tag, result, it.value);
                end
            end
            done_prev <= done;
        end else begin
            done_prev <= 1'b0;
        end
    end

    task automatic drive(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m);
        exponent  = e;
        modulus   = m;
        base_mont = to_mont(b, m);
        one_mont  = to_mont(W'(1), m);
    endtask

    // Driver: queue the expectation, pulse start, wait for completion.
    task automatic run_op(logic [W-1:0] b, logic [W-1:0] e, logic [W-1:0] m,
                          string tag, bit disturb);
        exp_item_t it;
        it.value = ref_pow(b, e, m);
        it.tag   = tag;
        sb_q.push_back(it);
        @(negedge clk);
        drive(b, e, m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (300) @(negedge clk);
            drive(~b % m, ~e, 32'hFFFF_FFFB);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [W-1:0] m;
        logic [W-1:0] held;
        checks = 0;
        fails  = 0;
        start  = 1'b0;
        rst_n  = 1'b0;
        drive('0, '0, 32'd3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R7 done after reset", {{(W-1){1'b0}}, done}, '0);
        check(result == '0, "R7 result after reset", result, '0);

        // Small modulus cases.
        run_op(32'd1570, 32'd1019, 32'd3337, "R1 small modulus", 1'b0);
        run_op(32'd1570, 32'd0,    32'd3337, "R3 zero exponent small", 1'b0);
        run_op(32'd0,    32'd77,   32'd3337, "R1 zero base", 1'b0);

        // Full-width moduli and exponent bit patterns.
        m = 32'hB4D9_2133;
        run_op(32'h1234_5678, 32'h0000_0000, m, "R3 zero exponent full width", 1'b0);
        run_op(32'h1234_5678, 32'h8000_0000, m, "R4 top exponent bit only", 1'b0);
        run_op(32'h1234_5678, 32'h0000_0001, m, "R4 bottom exponent bit only", 1'b0);
        run_op(32'h1234_5678, 32'hFFFF_FFFF, m, "R4 all exponent bits", 1'b0);
        run_op(32'hFFFF_FFFE, 32'h6F1E_6AB3, 32'hFFFF_FFFF, "R2 largest modulus, base M-1", 1'b0);
        for (int k = 0; k < 5; k++) begin
            logic [W-1:0] rm;
            rm = $urandom | 32'h8000_0001;
            run_op($urandom % rm, $urandom, rm, "R2 random full-width", 1'b0);
        end

        // R6: start with new operands in the middle of a run.
        run_op(32'h0BE5_416A, 32'h86A1_8F24, m, "R6 start during run ignored", 1'b1);

        // R6: start in the same cycle as done must not launch a new run.
        held = result;
        drive(32'd5, 32'd9, 32'd11);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        check(result == held, "R6 start with done ignored / R5 hold", result, held);
        check(sb_q.size() == 0, "R6 no pending run", W'(sb_q.size()), '0);

        // Idle again: a fresh start is accepted.
        run_op(32'd3, 32'd13, 32'd1001, "R1 after ignored start", 1'b0);
        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R1 scoreboard drained", W'(sb_q.size()), '0);
        finish_run();
    end

endmodule